// File: doc/BRIEF.md
# Predicate Register File with Compare

This block keeps the one-bit guard flags of a statically scheduled wide-issue core and evaluates the compare operations that set them. One compare can be accepted per cycle. It compares two 64-bit operands under a selected relation. The block then stores the outcome in one flag and the inverse outcome in a second flag. This lets the "then" and "else" halves of a branch-free if/else each be guarded by one of the pair.

Each issue slot presents the index of the flag that guards its operation. The block answers with an execute enable for that slot. When the enable is low, the slot's operation is to be squashed into a no-op with no architectural effect. Flag 0 always reads true, so unguarded operations name it. Both slots read in parallel and may name opposite flags in the same cycle. A compare updates the flags at the clock edge that ends its cycle. Reads in the same cycle still see the earlier values, because there is no forwarding path.

Top module: `pred_cmp_file`

## Requirements
- R1: After synchronous reset, every flag other than flag 0 reads false (execute enable 0).
- R2: A slot whose guard index is 0 always receives execute enable 1.
- R3: A compare that names flag 0 as either destination leaves flag 0 reading true.
- R4: Relation code 2'b00 yields true when the operands are equal.
- R5: Relation code 2'b01 yields true when the operands differ.
- R6: Relation code 2'b10 yields true when operand A is less than operand B, both read as two's-complement signed values.
- R7: Relation code 2'b11 yields true when operand A is less than operand B, both read as unsigned values.
- R8: A compare writes its outcome to the first destination and the inverse of its outcome to the second destination.
- R9: A compare's effect is first visible to guard reads in the cycle after the compare; a read of a destination in the compare's own cycle returns the old value.
- R10: When both destinations name the same flag, that flag receives the inverse outcome.
- R11: Each slot's execute enable equals the current value of the flag that the slot names, independently of the other slot.
- R12: In a cycle with the compare valid input low, no flag changes, whatever the other compare inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | A compare is presented this cycle |
| cmp_rel | input | 2 | Relation code (00 eq, 01 ne, 10 signed lt, 11 unsigned lt) |
| cmp_a | input | 64 | Operand A |
| cmp_b | input | 64 | Operand B |
| cmp_dst_t | input | 6 | Destination flag for the outcome |
| cmp_dst_f | input | 6 | Destination flag for the inverse outcome |
| slot_qp | input | 2x6 | Guard flag index for each issue slot |
| slot_exec | output | 2 | Execute enable per slot (0 means squash to no-op) |

## Verification
The hardest situation to reach is a read that names a flag while that same flag is being rewritten. The read must return the old value in that cycle and the new value one cycle later. The stimulus therefore points one slot at a compare's destination during the compare cycle, then probes again on the next cycle. Signed and unsigned relations are told apart with operand pairs whose sign bits differ, because these give opposite answers under the two codes. A long random run also lands on collisions of equal destinations and on destinations at flag 0.

// File: rtl/pred_pkg.sv
package pred_pkg;

    localparam int unsigned NUM_PREDS = 64;
    localparam int unsigned DATA_W    = 64;
    localparam int unsigned NUM_SLOTS = 2;
    localparam int unsigned PIDX_W    = $clog2(NUM_PREDS);

    typedef enum logic [1:0] {
        REL_EQ   = 2'd0,
        REL_NE   = 2'd1,
        REL_LT_S = 2'd2,
        REL_LT_U = 2'd3
    } rel_e;

    // Write request produced by the compare unit for the flag store.
    typedef struct packed {
        logic              valid;
        logic [PIDX_W-1:0] dst_t;
        logic [PIDX_W-1:0] dst_f;
        logic              res;
    } pwrite_t;

    // Signed less-than built from the unsigned result and the sign bits.
    function automatic logic signed_lt(input logic sa, input logic sb, input logic ult);
        return (sa != sb) ? sa : ult;
    endfunction

endpackage

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
    import pred_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned IW = PIDX_W
) (
    input  logic          valid,
    input  rel_e          rel,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [IW-1:0] dst_t,
    input  logic [IW-1:0] dst_f,
    output pwrite_t       wr
);
    logic eq, ult, slt, res;

    always_comb begin
        eq  = (a == b);
        ult = (a < b);
        slt = signed_lt(a[W-1], b[W-1], ult);
        unique case (rel)
            REL_EQ:   res = eq;
            REL_NE:   res = !eq;
            REL_LT_S: res = slt;
            REL_LT_U: res = ult;
            default:  res = 1'b0;
        endcase
    end

    always_comb begin
        wr.valid = valid;
        wr.dst_t = dst_t;
        wr.dst_f = dst_f;
        wr.res   = res;
    end
endmodule

// File: rtl/pred_store.sv
module pred_store
    import pred_pkg::*;
#(
    parameter int unsigned N = NUM_PREDS
) (
    input  logic         clk,
    input  logic         rst,
    input  pwrite_t      wr,
    output logic [N-1:0] bits
);
    for (genvar i = 0; i < N; i++) begin : g_reg
        if (i == 0) begin : g_true
            assign bits[i] = 1'b1;
        end else begin : g_flop
            logic q;
            logic hit_t, hit_f;
            assign hit_t = wr.valid && (wr.dst_t == PIDX_W'(i));
            assign hit_f = wr.valid && (wr.dst_f == PIDX_W'(i));
            always_ff @(posedge clk) begin
                if (rst)        q <= 1'b0;
                else if (hit_f) q <= !wr.res;   // inverse wins on collision
                else if (hit_t) q <= wr.res;
            end
            assign bits[i] = q;
        end
    end
endmodule

// File: rtl/pred_read_port.sv
module pred_read_port
    import pred_pkg::*;
#(
    parameter int unsigned N  = NUM_PREDS,
    parameter int unsigned IW = PIDX_W
) (
    input  logic [N-1:0]  bits,
    input  logic [IW-1:0] idx,
    output logic          en
);
    assign en = bits[idx];
endmodule

// File: rtl/pred_cmp_file.sv
module pred_cmp_file
    import pred_pkg::*;
#(
    parameter int unsigned NP = NUM_PREDS,
    parameter int unsigned W  = DATA_W,
    parameter int unsigned NS = NUM_SLOTS,
    localparam int unsigned IW = $clog2(NP)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmp_valid,
    input  logic [1:0]             cmp_rel,
    input  logic [W-1:0]           cmp_a,
    input  logic [W-1:0]           cmp_b,
    input  logic [IW-1:0]          cmp_dst_t,
    input  logic [IW-1:0]          cmp_dst_f,
    input  logic [NS-1:0][IW-1:0]  slot_qp,
    output logic [NS-1:0]          slot_exec
);
    pwrite_t        wr;
    logic [NP-1:0]  pred_q;

    pred_cmp_unit #(.W(W), .IW(IW)) u_cmp (
        .valid (cmp_valid),
        .rel   (rel_e'(cmp_rel)),
        .a     (cmp_a),
        .b     (cmp_b),
        .dst_t (cmp_dst_t),
        .dst_f (cmp_dst_f),
        .wr    (wr)
    );

    pred_store #(.N(NP)) u_store (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .bits (pred_q)
    );

    for (genvar s = 0; s < NS; s++) begin : g_slot
        pred_read_port #(.N(NP), .IW(IW)) u_rd (
            .bits (pred_q),
            .idx  (slot_qp[s]),
            .en   (slot_exec[s])
        );
    end
endmodule

// File: rtl/pred_cmp_file_chk.sv
module pred_cmp_file_chk #(
    parameter int unsigned NP = 64,
    parameter int unsigned W  = 64,
    parameter int unsigned NS = 2,
    localparam int unsigned IW = $clog2(NP)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cmp_valid,
    input logic [1:0]            cmp_rel,
    input logic [W-1:0]          cmp_a,
    input logic [W-1:0]          cmp_b,
    input logic [IW-1:0]         cmp_dst_t,
    input logic [IW-1:0]         cmp_dst_f,
    input logic [NS-1:0][IW-1:0] slot_qp,
    input logic [NS-1:0]         slot_exec,
    input logic [NP-1:0]         pred_q
);
    // R2
    p0_slot0_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_qp[0] == '0) |-> slot_exec[0]);
    // R2
    p0_slot1_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_qp[NS-1] == '0) |-> slot_exec[NS-1]);
    // R8
    compl_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_dst_t != '0 && cmp_dst_f != '0 && cmp_dst_t != cmp_dst_f)
        |=> (pred_q[$past(cmp_dst_t)] != pred_q[$past(cmp_dst_f)]));
    // R10
    same_dst_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_rel == 2'd0 && cmp_a == cmp_b && cmp_dst_t == cmp_dst_f && cmp_dst_t != '0)
        |=> !pred_q[$past(cmp_dst_t)]);
    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmp_valid |=> $stable(pred_q));
    // R3
    p0_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && (cmp_dst_t == '0 || cmp_dst_f == '0)) |=> pred_q[0]);
endmodule

bind pred_cmp_file pred_cmp_file_chk #(.NP(NP), .W(W), .NS(NS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmp_valid (cmp_valid),
    .cmp_rel   (cmp_rel),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b),
    .cmp_dst_t (cmp_dst_t),
    .cmp_dst_f (cmp_dst_f),
    .slot_qp   (slot_qp),
    .slot_exec (slot_exec),
    .pred_q    (pred_q)
);

// File: tb/tb_pred_cmp_file.sv
`timescale 1ns/1ps
module tb_pred_cmp_file;
    localparam int NP = 64;
    localparam int W  = 64;
    localparam int IW = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmp_valid = 1'b0;
    logic [1:0]        cmp_rel = 2'd0;
    logic [W-1:0]      cmp_a = '0;
    logic [W-1:0]      cmp_b = '0;
    logic [IW-1:0]     cmp_dst_t = '0;
    logic [IW-1:0]     cmp_dst_f = '0;
    logic [1:0][IW-1:0] slot_qp = '0;
    logic [1:0]        slot_exec;

    always #2.5 clk = ~clk;

    pred_cmp_file dut (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_rel(cmp_rel),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f),
        .slot_qp(slot_qp), .slot_exec(slot_exec)
    );

    typedef struct {
        int    slot;
        logic  exp;
        string tag;
    } item_t;

    item_t  sb_q[$];
    logic   model [NP];
    int     n_run  = 0;
    int     n_fail = 0;
    bit     done   = 0;

    function automatic logic ref_rel(input logic [1:0] r, input logic [W-1:0] a, input logic [W-1:0] b);
        case (r)
            2'd0:    return a == b;
            2'd1:    return a != b;
            2'd2:    return $signed(a) < $signed(b);
            default: return a < b;
        endcase
    endfunction

    // Driver: one cycle of stimulus; expectations come from the model before the edge.
    task automatic step(input logic v, input logic [1:0] r, input logic [W-1:0] a,
                        input logic [W-1:0] b, input int dt, input int df,
                        input int q0, input int q1, input string tag);
        item_t it;
        logic  res;
        @(negedge clk);
        cmp_valid = v; cmp_rel = r; cmp_a = a; cmp_b = b;
        cmp_dst_t = IW'(dt); cmp_dst_f = IW'(df);
        slot_qp[0] = IW'(q0); slot_qp[1] = IW'(q1);
        it.slot = 0; it.exp = model[q0]; it.tag = tag; sb_q.push_back(it);
        it.slot = 1; it.exp = model[q1]; it.tag = tag; sb_q.push_back(it);
        @(posedge clk);
        if (v) begin
            res = ref_rel(r, a, b);
            if (dt != 0) model[dt] = res;
            if (df != 0) model[df] = !res;
        end
    endtask

    task automatic probe(input int q0, input int q1, input string tag);
        step(1'b0, 2'd3, '1, '0, q0, q1, q0, q1, tag);
    endtask

    // Monitor: compares the outputs away from the clock edge.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                n_run++;
                if (slot_exec[it.slot] !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s slot%0d actual=%b expected=%b", it.tag, it.slot,
                             slot_exec[it.slot], it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP; i++) model[i] = (i == 0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state across every flag, R2 on flag 0
        for (int i = 0; i < NP; i += 2) probe(i, i + 1, "R1");
        probe(0, 0, "R2");

        // R4 equal operands, R8 pair, R9 same-cycle read sees old value
        step(1'b1, 2'd0, 64'd42, 64'd42, 1, 2, 1, 2, "R9 same cycle");
        probe(1, 2, "R4/R8 eq");
        step(1'b1, 2'd0, 64'd42, 64'd43, 1, 2, 1, 2, "R9 same cycle");
        probe(1, 2, "R4 ne operands");
        // R5
        step(1'b1, 2'd1, 64'd7, 64'd9, 3, 4, 0, 0, "R5");
        probe(3, 4, "R5 differ");
        step(1'b1, 2'd1, 64'd9, 64'd9, 3, 4, 0, 0, "R5");
        probe(3, 4, "R5 equal");
        // R6 / R7 with differing sign bits
        step(1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5, 6, 0, 0, "R6");
        probe(5, 6, "R6 neg<pos");
        step(1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 7, 8, 0, 0, "R7");
        probe(7, 8, "R7 big<1 false");
        step(1'b1, 2'd2, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 9, 10, 0, 0, "R6");
        probe(9, 10, "R6 min<max");
        step(1'b1, 2'd3, 64'd3, 64'd5, 11, 12, 0, 0, "R7");
        probe(11, 12, "R7 3<5");
        // R3 writes to flag 0 discarded
        step(1'b1, 2'd0, 64'd1, 64'd2, 0, 13, 0, 13, "R3");
        probe(0, 13, "R3 dst_t=0");
        step(1'b1, 2'd0, 64'd1, 64'd1, 14, 0, 0, 14, "R3");
        probe(0, 14, "R3 dst_f=0");
        // R10 collision: inverse wins
        step(1'b1, 2'd0, 64'd5, 64'd5, 20, 20, 0, 0, "R10");
        probe(20, 20, "R10 eq true -> 0");
        step(1'b1, 2'd1, 64'd5, 64'd5, 20, 20, 0, 0, "R10");
        probe(20, 20, "R10 ne false -> 1");
        // R12 idle cycle with live-looking fields
        step(1'b0, 2'd1, 64'd1, 64'd2, 20, 21, 20, 21, "R12");
        probe(20, 21, "R12 hold");
        // R11 opposite flags in the same cycle
        step(1'b1, 2'd3, 64'd1, 64'd2, 30, 31, 0, 0, "R11");
        probe(30, 31, "R11 opposite");
        probe(31, 30, "R11 swapped");
        // Random run
        for (int k = 0; k < 400; k++) begin
            step(1'($urandom_range(0, 3) != 0), 2'($urandom), {$urandom, 28'd0, 4'($urandom)},
                 {$urandom, 28'd0, 4'($urandom)}, $urandom_range(0, 63), $urandom_range(0, 63),
                 $urandom_range(0, 63), $urandom_range(0, 63), "R11 random");
        end
        probe(0, 1, "R2 final");
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule